// File: doc/BRIEF.md
# Four-Channel Dithered Fractional PWM Generator

This block produces four pulse-width-modulated outputs from one shared 8-bit timebase running on the system clock. Every output repeats over a full cycle of 256 clocks. That full cycle is divided into shorter sub-periods, called modulation cycles. Each channel takes an 8-bit duty value and splits it into two parts:

- a coarse part, which sets how many clocks each sub-period stays high;
- a low-order dither part, which adds one extra high clock to the first few sub-periods.

The fraction therefore averages out correctly over the whole 256-clock cycle, while each sub-period repeats at a higher rate than the full cycle would.

A static split input chooses between two arrangements:

- four sub-periods of 64 clocks, with a 6-bit coarse part and a 2-bit dither part;
- two sub-periods of 128 clocks, with a 7-bit coarse part and a 1-bit dither part.

Duty values arrive through a simple write strobe with a channel index. A per-channel shadow state machine holds a new value until the full cycle wraps, so a running cycle is never cut short. The shadow machine has two states:

- `SH_CLEAN`: nothing is waiting. A write strobe outside the last clock of the cycle moves it to `SH_PENDING`. A write in the last clock is copied straight into the live duty, and the machine stays in `SH_CLEAN`.
- `SH_PENDING`: a value is waiting in the shadow register. At the wrap clock it copies the value into the live duty and returns to `SH_CLEAN`.

Each pin then passes through a gate driven by a PWM-enable bit and a data bit, and is registered before it leaves the block.

Top module: `dpwm_quad`

## Requirements
- R1: A single 8-bit counter shared by all channels resets to 0 and advances by one every clock, wrapping from 255 to 0, so every channel repeats with a period of 256 clocks.
- R2: With `split_mode` = 0, the counter bits [7:6] give the sub-period index (0..3) and bits [5:0] give the position inside it. The duty bits [7:2] are the coarse count DC and bits [1:0] are the dither count AC.
- R3: With `split_mode` = 0, sub-period i is high for DC+1 clocks when i < AC and for DC clocks otherwise. For example, a duty of 100 gives 25 high clocks in all four sub-periods, and 101 gives 26, 25, 25, 25.
- R4: With `split_mode` = 1, counter bit [7] is the index and bits [6:0] the position, DC is duty bits [7:1] and AC is bit [0]. For example, a duty of 101 gives 51 then 50 high clocks, and 255 gives 128 then 127.
- R5: Inside each sub-period the raw waveform is high from its first clock without a break and then low for the rest of it. A duty of 0 gives a constant low output.
- R6: A duty write becomes visible from the first clock of the next full 256-clock cycle, and the cycle in progress keeps its old value. A write during the last clock of a cycle (counter = 255) applies from the very next clock. A later write before the wrap replaces an earlier pending one.
- R7: When `pin_pwm_en[k]` = 1, output k is the PWM waveform ANDed with `pin_data[k]`. When `pin_pwm_en[k]` = 0, output k follows `pin_data[k]`.
- R8: Each output is registered: the value on `pwm_out[k]` during a clock reflects the counter value and the pin inputs of the clock before.
- R9: A synchronous reset clears the counter, all live and pending duty values, and all outputs to 0.
- R10: A write with `wr_en` = 1 updates only the channel selected by `wr_chan` (channel index 0..3). The other channels keep their duty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| split_mode | input | 1 | 0: four 64-clock sub-periods (6+2); 1: two 128-clock sub-periods (7+1). Static |
| wr_en | input | 1 | Duty write strobe |
| wr_chan | input | 2 | Channel index for the write |
| wr_data | input | 8 | Duty value to write |
| pin_pwm_en | input | 4 | Per-pin PWM select |
| pin_data | input | 4 | Per-pin data bit |
| pwm_out | output | 4 | Registered pin outputs |

## Verification
After reset is released, the counter value that drives the output of a given clock equals the number of active edges since the release minus one, modulo 256, and `pwm_out` shows that result one clock later. The bench counts its own edges from the release. It samples 1 ns after each edge. It compares each sample with the position that edge count implies, which makes every comparison sensitive to both the one-clock output latency and the sub-period boundaries. A duty write is judged only over the full 256-clock cycle that follows the wrap, and a write made inside a cycle is also checked against that same cycle to confirm the old value still holds there. Pin gating changes are made before a window starts, so the one-clock register delay on the pin inputs is already settled when sampling begins.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;

    // Split selector for the duty word
    typedef enum logic {
        SPLIT_6_2 = 1'b0,
        SPLIT_7_1 = 1'b1
    } split_e;

    // Per-channel shadow register state
    typedef enum logic [1:0] {
        SH_CLEAN   = 2'b01,
        SH_PENDING = 2'b10
    } shadow_e;

endpackage

// File: rtl/dpwm_timebase.sv
module dpwm_timebase #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o  = cnt_q;
    assign wrap_o = (cnt_q == CNT_MAX);

    // R1: counter advances by one every clock out of reset
    p_cnt_advance_r1: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

    // R9: reset leaves counter at zero
    p_cnt_reset_r9: assert property (@(posedge clk)
        $past(rst) |-> (cnt_q == '0));

endmodule

// File: rtl/dpwm_shadow.sv
module dpwm_shadow
    import dpwm_pkg::*;
#(
    parameter int DUTY_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_hit_i,
    input  logic [DUTY_W-1:0] wr_data_i,
    input  logic              wrap_i,
    output logic [DUTY_W-1:0] duty_o
);
    shadow_e           state_q, state_d;
    logic [DUTY_W-1:0] pend_q;
    logic [DUTY_W-1:0] active_q;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SH_CLEAN;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SH_CLEAN: begin
                if (wr_hit_i && !wrap_i) begin
                    state_d = SH_PENDING;
                end
            end
            SH_PENDING: begin
                if (wrap_i) begin
                    state_d = SH_CLEAN;
                end
            end
            default: state_d = SH_CLEAN;
        endcase
    end

    // Shadow and live duty registers
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q   <= '0;
            active_q <= '0;
        end else begin
            if (wr_hit_i) begin
                pend_q <= wr_data_i;
            end
            if (wrap_i) begin
                if (wr_hit_i) begin
                    active_q <= wr_data_i;
                end else if (state_q == SH_PENDING) begin
                    active_q <= pend_q;
                end
            end
        end
    end

    assign duty_o = active_q;

    // R6: live duty is frozen away from the cycle wrap
    p_hold_mid_cycle_r6: assert property (@(posedge clk) disable iff (rst)
        !wrap_i |=> $stable(active_q));

    // R6: a pending value is installed at the wrap
    p_pending_lands_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == SH_PENDING && wrap_i && !wr_hit_i) |=> (active_q == $past(pend_q)));

    // R6: a write on the wrap clock lands directly
    p_wrap_write_r6: assert property (@(posedge clk) disable iff (rst)
        (wrap_i && wr_hit_i) |=> (active_q == $past(wr_data_i)));

    // R9: reset clears the live duty
    p_duty_reset_r9: assert property (@(posedge clk)
        $past(rst) |-> (active_q == '0));

endmodule

// File: rtl/dpwm_compare.sv
module dpwm_compare
    import dpwm_pkg::*;
#(
    parameter int DUTY_W = 8,
    parameter int FINE_A = 2,
    parameter int FINE_B = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  split_e            split_i,
    input  logic [DUTY_W-1:0] cnt_i,
    input  logic [DUTY_W-1:0] duty_i,
    input  logic              pwm_en_i,
    input  logic              data_i,
    output logic              out_o
);
    localparam int CW = DUTY_W + 1;

    logic raw_a, raw_b, raw, gated, out_q;

    // High when in-slot position is below coarse + dither bonus
    function automatic logic slot_high(
        input logic [DUTY_W-1:0] cnt,
        input logic [DUTY_W-1:0] duty,
        input int                fine
    );
        logic [CW-1:0] pos_mask, fine_mask, phase, idx, dc, ac, eff;
        pos_mask  = (CW'(1) << (DUTY_W - fine)) - CW'(1);
        fine_mask = (CW'(1) << fine) - CW'(1);
        phase     = {1'b0, cnt} & pos_mask;
        idx       = {1'b0, cnt} >> (DUTY_W - fine);
        dc        = {1'b0, duty} >> fine;
        ac        = {1'b0, duty} & fine_mask;
        eff       = dc + ((idx < ac) ? CW'(1) : CW'(0));
        return (phase < eff);
    endfunction

    always_comb begin
        raw_a = slot_high(cnt_i, duty_i, FINE_A);
        raw_b = slot_high(cnt_i, duty_i, FINE_B);
        unique case (split_i)
            SPLIT_6_2: raw = raw_a;
            SPLIT_7_1: raw = raw_b;
            default:   raw = raw_a;
        endcase
        gated = pwm_en_i ? (raw & data_i) : data_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= 1'b0;
        end else begin
            out_q <= gated;
        end
    end

    assign out_o = out_q;

    // R7: data bit of 0 forces PWM pin low
    p_gate_low_r7: assert property (@(posedge clk) disable iff (rst)
        (pwm_en_i && !data_i) |=> !out_o);

    // R7: plain pin follows its data bit
    p_plain_pin_r7: assert property (@(posedge clk) disable iff (rst)
        !pwm_en_i |=> (out_o == $past(data_i)));

    // R5: zero duty never drives high
    p_zero_duty_low_r5: assert property (@(posedge clk) disable iff (rst)
        (pwm_en_i && duty_i == '0) |=> !out_o);

    // R9: output low right after reset
    p_out_reset_r9: assert property (@(posedge clk)
        $past(rst) |-> !out_o);

endmodule

// File: rtl/dpwm_quad.sv
module dpwm_quad
    import dpwm_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int DUTY_W = 8,
    parameter int FINE_A = 2,
    parameter int FINE_B = 1,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              split_mode,
    input  logic              wr_en,
    input  logic [CH_W-1:0]   wr_chan,
    input  logic [DUTY_W-1:0] wr_data,
    input  logic [NUM_CH-1:0] pin_pwm_en,
    input  logic [NUM_CH-1:0] pin_data,
    output logic [NUM_CH-1:0] pwm_out
);
    logic [DUTY_W-1:0] cnt;
    logic              wrap;
    split_e            split;

    assign split = split_e'(split_mode);

    dpwm_timebase #(.CNT_W(DUTY_W)) u_tb (
        .clk    (clk),
        .rst    (rst),
        .cnt_o  (cnt),
        .wrap_o (wrap)
    );

    logic [NUM_CH-1:0] wr_hit;

    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
        logic [DUTY_W-1:0] duty;

        assign wr_hit[k] = wr_en && (wr_chan == CH_W'(k));

        dpwm_shadow #(.DUTY_W(DUTY_W)) u_sh (
            .clk       (clk),
            .rst       (rst),
            .wr_hit_i  (wr_hit[k]),
            .wr_data_i (wr_data),
            .wrap_i    (wrap),
            .duty_o    (duty)
        );

        dpwm_compare #(
            .DUTY_W (DUTY_W),
            .FINE_A (FINE_A),
            .FINE_B (FINE_B)
        ) u_cmp (
            .clk      (clk),
            .rst      (rst),
            .split_i  (split),
            .cnt_i    (cnt),
            .duty_i   (duty),
            .pwm_en_i (pin_pwm_en[k]),
            .data_i   (pin_data[k]),
            .out_o    (pwm_out[k])
        );
    end

    // R10: a write strobe reaches at most one channel
    p_one_target_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_hit));

endmodule

// File: tb/dpwm_quad_tb_top.sv
module dpwm_quad_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       split_mode = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_chan = '0;
    logic [7:0] wr_data = '0;
    logic [3:0] pin_pwm_en = 4'hF;
    logic [3:0] pin_data = 4'hF;
    logic [3:0] pwm_out;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;   // 125 MHz

    dpwm_quad dut_i (
        .clk        (clk),
        .rst        (rst),
        .split_mode (split_mode),
        .wr_en      (wr_en),
        .wr_chan    (wr_chan),
        .wr_data    (wr_data),
        .pin_pwm_en (pin_pwm_en),
        .pin_data   (pin_data),
        .pwm_out    (pwm_out)
    );

    // {mode, chan, duty, e0, e1, e2, e3}: high clocks per sub-period
    localparam logic [42:0] VEC [10] = '{
        {1'b0, 2'd0, 8'd100, 8'd25,  8'd25,  8'd25, 8'd25},
        {1'b0, 2'd1, 8'd101, 8'd26,  8'd25,  8'd25, 8'd25},
        {1'b0, 2'd2, 8'd103, 8'd26,  8'd26,  8'd26, 8'd25},
        {1'b0, 2'd3, 8'd255, 8'd64,  8'd64,  8'd64, 8'd63},
        {1'b0, 2'd0, 8'd0,   8'd0,   8'd0,   8'd0,  8'd0},
        {1'b0, 2'd1, 8'd1,   8'd1,   8'd0,   8'd0,  8'd0},
        {1'b1, 2'd2, 8'd101, 8'd51,  8'd50,  8'd0,  8'd0},
        {1'b1, 2'd3, 8'd255, 8'd128, 8'd127, 8'd0,  8'd0},
        {1'b1, 2'd0, 8'd2,   8'd1,   8'd1,   8'd0,  8'd0},
        {1'b1, 2'd1, 8'd1,   8'd1,   8'd0,   8'd0,  8'd0}
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset(input logic mode);
        split_mode = mode;
        wr_en = 1'b0;
        rst = 1'b1;
        repeat (3) tick();
        rst = 1'b0;
    endtask

    task automatic write(input logic [1:0] ch, input logic [7:0] d);
        wr_en = 1'b1;
        wr_chan = ch;
        wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    // One full 256-clock window; sample j reflects counter position j.
    // Optional in-window writes to channel wch at positions wa and wb.
    task automatic check_window(
        input logic [3:0][3:0][7:0] e,
        input string               tag,
        input int                  wa,
        input logic [7:0]          da,
        input int                  wb,
        input logic [7:0]          db,
        input logic [1:0]          wch
    );
        int  bad [4];
        int  first_j [4];
        logic first_act [4];
        logic first_exp [4];
        for (int c = 0; c < 4; c++) begin
            bad[c] = 0;
            first_j[c] = 0;
            first_act[c] = 1'b0;
            first_exp[c] = 1'b0;
        end
        for (int j = 0; j < 256; j++) begin
            if (j == wa || j == wb) begin
                wr_en = 1'b1;
                wr_chan = wch;
                wr_data = (j == wa) ? da : db;
            end
            tick();
            wr_en = 1'b0;
            for (int c = 0; c < 4; c++) begin
                int   idx;
                int   ph;
                logic expb;
                idx = split_mode ? (j / 128) : (j / 64);
                ph  = split_mode ? (j % 128) : (j % 64);
                expb = pin_pwm_en[c] ? (pin_data[c] && (ph < int'(e[c][idx]))) : pin_data[c];
                if (pwm_out[c] !== expb) begin
                    if (bad[c] == 0) begin
                        first_j[c] = j;
                        first_act[c] = pwm_out[c];
                        first_exp[c] = expb;
                    end
                    bad[c]++;
                end
            end
        end
        for (int c = 0; c < 4; c++) begin
            checks++;
            if (bad[c] != 0) begin
                errors++;
                $display("FAIL %s ch%0d pos %0d actual %b expected %b (%0d mismatches)",
                         tag, c, first_j[c], first_act[c], first_exp[c], bad[c]);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [3:0][3:0][7:0] e;

        // R9: outputs low in and right after reset
        do_reset(1'b0);
        checks++;
        if (pwm_out !== 4'h0) begin
            errors++;
            $display("FAIL R9 reset out actual %h expected 0", pwm_out);
        end

        // Vector table: R1 R2 R3 R4 R5 R8 R10
        for (int v = 0; v < 10; v++) begin
            logic       m;
            logic [1:0] ch;
            m  = VEC[v][42];
            ch = VEC[v][41:40];
            do_reset(m);
            pin_pwm_en = 4'hF;
            pin_data = 4'hF;
            write(ch, VEC[v][39:32]);
            repeat (255) tick();
            e = '0;
            e[ch][0] = VEC[v][31:24];
            e[ch][1] = VEC[v][23:16];
            e[ch][2] = VEC[v][15:8];
            e[ch][3] = VEC[v][7:0];
            check_window(e, m ? "R4 R5 R8 R10 R1" : "R2 R3 R5 R8 R10 R1", -1, 8'h0, -1, 8'h0, 2'd0);
        end

        // R6: shadow behaviour across three consecutive cycles
        do_reset(1'b0);
        write(2'd0, 8'd100);
        repeat (255) tick();
        e = '0;
        e[0] = {8'd25, 8'd25, 8'd25, 8'd25};
        check_window(e, "R6 mid-cycle write held", 100, 8'd255, -1, 8'h0, 2'd0);
        e[0] = {8'd63, 8'd64, 8'd64, 8'd64};
        check_window(e, "R6 applied next cycle", 255, 8'd101, -1, 8'h0, 2'd0);
        e[0] = {8'd25, 8'd25, 8'd25, 8'd26};
        check_window(e, "R6 wrap-clock write", 10, 8'd4, 20, 8'd8, 2'd0);
        e[0] = {8'd2, 8'd2, 8'd2, 8'd2};
        check_window(e, "R6 last write wins", -1, 8'h0, -1, 8'h0, 2'd0);

        // R7: pin gating
        do_reset(1'b0);
        pin_pwm_en = 4'b0011;
        pin_data   = 4'b0110;
        write(2'd0, 8'h80);
        write(2'd1, 8'h80);
        write(2'd2, 8'h80);
        write(2'd3, 8'h80);
        repeat (252) tick();
        e = '0;
        e[0] = {4{8'd32}};
        e[1] = {4{8'd32}};
        check_window(e, "R7 gating", -1, 8'h0, -1, 8'h0, 2'd0);

        // R9: reset mid-run clears outputs and duty
        pin_pwm_en = 4'hF;
        pin_data = 4'hF;
        write(2'd2, 8'd255);
        repeat (300) tick();
        rst = 1'b1;
        tick();
        checks++;
        if (pwm_out !== 4'h0) begin
            errors++;
            $display("FAIL R9 mid-run reset out actual %h expected 0", pwm_out);
        end
        rst = 1'b0;
        repeat (256) tick();
        e = '0;
        check_window(e, "R9 duty cleared", -1, 8'h0, -1, 8'h0, 2'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule